// File: doc/BRIEF.md
# Virtualization-Aware Interrupt Selector

This block decides, within a single evaluation and with no internal state, whether a hart that supports a hypervisor mode must take an interrupt now, which cause number to report, and whether the trap must land at the hypervisor level. Its inputs are the pending word, the enable word, the machine delegation mask, three global enable bits (machine, supervisor, and the hypervisor-side copy of the supervisor bit), the current privilege level and a flag that is high while a guest runs.

When no guest runs, the candidates are the enabled pending interrupts without the three guest-supervisor bits. Each candidate is gated by the machine or supervisor global enable, depending on whether it is delegated. When a guest runs, host-level candidates are checked first under the hypervisor enable, and any of them forces a hypervisor trap. If none qualifies, the guest bits are moved down one position onto the supervisor slots and then pass through the same delegation gate. The lowest cause number always wins.

Top module: `vint_sel`

## Requirements
- R1: When the guest flag is low, enabled pending bits at the guest-supervisor positions 2, 6 and 10 never produce an interrupt. All other bits that are both pending and enabled are candidates.
- R2: A candidate whose delegation bit is 0 is taken only when the machine gate is open. The gate is open when the privilege code is 0 (user), 1 (supervisor) or 2 (reserved), or when it is 3 (machine) with the machine enable set.
- R3: A candidate whose delegation bit is 1 is taken only when the supervisor gate is open. The gate is open when the privilege code is 0, or when it is 1 with the supervisor enable set. It is shut for codes 2 and 3.
- R4: Each candidate is gated only by the gate its own delegation bit selects. A delegated and a non-delegated candidate in the same word are judged independently.
- R5: When several candidates survive, the output cause is the lowest surviving bit index.
- R6: When the guest flag is high, a non-guest candidate gated by the hypervisor gate wins over every guest bit. It drives the valid output high, the cause to its index and the hypervisor-trap output high.
- R7: The hypervisor gate follows the privilege test of R3 but uses the hypervisor-side enable bit. With a guest running at privilege 1, that bit alone decides whether non-guest candidates are seen, and those that are not seen are dropped instead of reaching the delegation gate.
- R8: When the guest flag is high and no hypervisor candidate exists, the enabled pending bits at 2, 6 and 10 are reported at 1, 5 and 9. They pass the delegation gate of R2 and R3 using the mask bits at 1, 5 and 9, and the hypervisor-trap output is low.
- R9: When nothing survives, the valid output, the hypervisor-trap output and the cause are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_word | input | XLEN | Interrupt-pending bits |
| en_word | input | XLEN | Interrupt-enable bits |
| deleg_word | input | XLEN | 1 = delegated to supervisor level |
| m_glob_ie | input | 1 | Machine global enable |
| s_glob_ie | input | 1 | Supervisor global enable |
| hyp_s_ie | input | 1 | Hypervisor-side copy of the supervisor enable |
| cur_priv | input | 2 | Privilege code: 0 user, 1 supervisor, 3 machine |
| guest_on | input | 1 | High while a guest runs |
| take_irq | output | 1 | An interrupt must be taken |
| irq_cause | output | $clog2(XLEN) | Index of the chosen cause |
| trap_to_hyp | output | 1 | Forces the trap to the hypervisor level |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle as the stimulus and has no register on its path. The bench changes inputs just after a rising clock edge and compares all three outputs at the following falling edge, half a period later. That leaves settled logic and keeps the outcome free of process ordering. Directed vectors cover each gate and privilege code, then thousands of mixed vectors are compared against a loop-based reference model.

// File: rtl/vint_sel_pkg.sv
package vint_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_USR  = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_MCH  = 2'd3
    } priv_e;

    // supervisor slots; guest slots sit one bit higher
    localparam int unsigned SLOT_SW   = 1;
    localparam int unsigned SLOT_TIM  = 5;
    localparam int unsigned SLOT_EXT  = 9;
    localparam int unsigned GUEST_OFS = 1;

    typedef struct packed {
        logic mch;
        logic sup;
        logic hyp;
    } gate_t;

    function automatic logic level_open(input logic [1:0] cur,
                                        input logic [1:0] lvl,
                                        input logic       ie);
        return (cur < lvl) || ((cur == lvl) && ie);
    endfunction

    function automatic logic is_guest_slot(input int unsigned idx);
        return (idx == SLOT_SW + GUEST_OFS) ||
               (idx == SLOT_TIM + GUEST_OFS) ||
               (idx == SLOT_EXT + GUEST_OFS);
    endfunction

endpackage

// File: rtl/vint_gates.sv
module vint_gates
    import vint_sel_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       m_glob_ie,
    input  logic       s_glob_ie,
    input  logic       hyp_s_ie,
    output gate_t      gates
);
    always_comb begin
        gates.mch = level_open(cur_priv, PRIV_MCH, m_glob_ie);
        gates.sup = level_open(cur_priv, PRIV_SUP, s_glob_ie);
        gates.hyp = level_open(cur_priv, PRIV_SUP, hyp_s_ie);
    end
endmodule

// File: rtl/vint_split.sv
module vint_split
    import vint_sel_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] pend_word,
    input  logic [XLEN-1:0] en_word,
    output logic [XLEN-1:0] host_set,
    output logic [XLEN-1:0] guest_set
);
    logic [XLEN-1:0] guest_mask;
    logic [XLEN-1:0] live;

    for (genvar k = 0; k < XLEN; k++) begin : g_mask
        assign guest_mask[k] = is_guest_slot(k);
    end

    assign live      = pend_word & en_word;
    assign host_set  = live & ~guest_mask;
    assign guest_set = (live & guest_mask) >> GUEST_OFS;
endmodule

// File: rtl/vint_lsb.sv
module vint_lsb #(
    parameter int unsigned W  = 64,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/vint_sel.sv
module vint_sel
    import vint_sel_pkg::*;
#(
    parameter  int unsigned XLEN    = 64,
    localparam int unsigned CAUSE_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]    pend_word,
    input  logic [XLEN-1:0]    en_word,
    input  logic [XLEN-1:0]    deleg_word,
    input  logic               m_glob_ie,
    input  logic               s_glob_ie,
    input  logic               hyp_s_ie,
    input  logic [1:0]         cur_priv,
    input  logic               guest_on,
    output logic               take_irq,
    output logic [CAUSE_W-1:0] irq_cause,
    output logic               trap_to_hyp
);
    gate_t               gates;
    logic [XLEN-1:0]     host_set;
    logic [XLEN-1:0]     guest_set;
    logic [XLEN-1:0]     hyp_set;
    logic [XLEN-1:0]     base_set;
    logic [XLEN-1:0]     final_set;
    logic                hyp_any;
    logic                fin_any;
    logic [CAUSE_W-1:0]  hyp_idx;
    logic [CAUSE_W-1:0]  fin_idx;

    vint_gates u_gates (
        .cur_priv  (cur_priv),
        .m_glob_ie (m_glob_ie),
        .s_glob_ie (s_glob_ie),
        .hyp_s_ie  (hyp_s_ie),
        .gates     (gates)
    );

    vint_split #(.XLEN(XLEN)) u_split (
        .pend_word (pend_word),
        .en_word   (en_word),
        .host_set  (host_set),
        .guest_set (guest_set)
    );

    assign hyp_set   = host_set & {XLEN{guest_on & gates.hyp}};
    assign base_set  = guest_on ? guest_set : host_set;
    assign final_set = (base_set & ~deleg_word & {XLEN{gates.mch}}) |
                       (base_set &  deleg_word & {XLEN{gates.sup}});

    vint_lsb #(.W(XLEN), .IW(CAUSE_W)) u_hyp_pick (
        .vec (hyp_set),
        .any (hyp_any),
        .idx (hyp_idx)
    );

    vint_lsb #(.W(XLEN), .IW(CAUSE_W)) u_fin_pick (
        .vec (final_set),
        .any (fin_any),
        .idx (fin_idx)
    );

    always_comb begin
        if (hyp_any) begin
            take_irq    = 1'b1;
            irq_cause   = hyp_idx;
            trap_to_hyp = 1'b1;
        end else begin
            take_irq    = fin_any;
            irq_cause   = fin_any ? fin_idx : '0;
            trap_to_hyp = 1'b0;
        end
    end
endmodule

// File: rtl/vint_sel_chk.sv
module vint_sel_chk #(
    parameter  int unsigned XLEN    = 64,
    localparam int unsigned CAUSE_W = $clog2(XLEN)
) (
    input logic [XLEN-1:0]    pend_word,
    input logic [XLEN-1:0]    en_word,
    input logic               guest_on,
    input logic               take_irq,
    input logic [CAUSE_W-1:0] irq_cause,
    input logic               trap_to_hyp
);
    always_comb begin
        AST_HYP_NEEDS_GUEST: assert (!trap_to_hyp || guest_on); // R6
        AST_HYP_NEEDS_VALID: assert (!trap_to_hyp || take_irq); // R9
        AST_IDLE_CAUSE_ZERO: assert (take_irq || irq_cause == '0); // R9
        AST_HOST_CAUSE_LIVE: assert (!(take_irq && !guest_on) ||
                                     (pend_word[irq_cause] && en_word[irq_cause])); // R1
        AST_NO_GUEST_SLOT_HOST: assert (!(take_irq && !guest_on) ||
                                        !(irq_cause == 2 || irq_cause == 6 || irq_cause == 10)); // R1
        AST_GUEST_ON_SUP_SLOT: assert (!(take_irq && guest_on && !trap_to_hyp) ||
                                       (irq_cause == 1 || irq_cause == 5 || irq_cause == 9)); // R8
    end
endmodule

bind vint_sel vint_sel_chk #(.XLEN(XLEN)) u_chk (
    .pend_word   (pend_word),
    .en_word     (en_word),
    .guest_on    (guest_on),
    .take_irq    (take_irq),
    .irq_cause   (irq_cause),
    .trap_to_hyp (trap_to_hyp)
);

// File: tb/sim_vint_sel.sv
`timescale 1ns/1ps
module sim_vint_sel;
    localparam int XLEN = 64;
    localparam int CW   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [XLEN-1:0] pend, en, deleg;
    logic            mie, sie, hie, gon;
    logic [1:0]      priv;
    logic            v_o, h_o;
    logic [CW-1:0]   c_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    vint_sel #(.XLEN(XLEN)) u0 (
        .pend_word(pend), .en_word(en), .deleg_word(deleg),
        .m_glob_ie(mie), .s_glob_ie(sie), .hyp_s_ie(hie),
        .cur_priv(priv), .guest_on(gon),
        .take_irq(v_o), .irq_cause(c_o), .trap_to_hyp(h_o)
    );

    // behavioural reference, bit by bit
    task automatic model(output bit ev, output int ec, output bit eh);
        bit m_ok, s_ok, h_ok;
        m_ok = (priv != 3) || mie;
        s_ok = (priv == 0) || (priv == 1 && sie);
        h_ok = (priv == 0) || (priv == 1 && hie);
        ev = 0; ec = 0; eh = 0;
        if (gon && h_ok) begin
            for (int i = 0; i < XLEN; i++) begin
                if (!ev && pend[i] && en[i] && !(i == 2 || i == 6 || i == 10)) begin
                    ev = 1; ec = i; eh = 1;
                end
            end
        end
        if (!ev) begin
            for (int i = 0; i < XLEN; i++) begin
                bit cand;
                if (gon) cand = (i == 1 || i == 5 || i == 9) && pend[i+1] && en[i+1];
                else     cand = pend[i] && en[i] && !(i == 2 || i == 6 || i == 10);
                if (!ev && cand && (deleg[i] ? s_ok : m_ok)) begin
                    ev = 1; ec = i;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        bit ev, eh; int ec;
        model(ev, ec, eh);
        checks++;
        if (v_o !== ev || int'(c_o) !== ec || h_o !== eh) begin
            errors++;
            $display("FAIL %s: got valid=%0b cause=%0d hyp=%0b, expected valid=%0b cause=%0d hyp=%0b",
                     tag, v_o, c_o, h_o, ev, ec, eh);
        end
    endtask

    task automatic apply(input logic [XLEN-1:0] p, e, d, input logic m, s, h,
                         input logic [1:0] pr, input logic g, input string tag);
        @(posedge clk); #0.5;
        pend = p; en = e; deleg = d; mie = m; sie = s; hie = h; priv = pr; gon = g;
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [XLEN-1:0] b(input int i);
        return {{(XLEN-1){1'b0}}, 1'b1} << i;
    endfunction

    initial begin
        pend = '0; en = '0; deleg = '0; mie = 0; sie = 0; hie = 0; priv = 2'd0; gon = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); compare("R9 idle after reset");
        apply('0, '1, '0, 1, 1, 1, 0, 0, "R9 nothing pending");
        // R1 guest slots ignored outside guest mode
        apply(b(6) | b(2) | b(10), '1, '0, 1, 1, 1, 0, 0, "R1 guest bits host mode");
        apply(b(6) | b(13), '1, '0, 1, 1, 1, 0, 0, "R1 guest bit skipped, 13 taken");
        // R2 machine gate
        apply(b(7), b(7), '0, 0, 0, 0, 3, 0, "R2 machine, mie off");
        apply(b(7), b(7), '0, 1, 0, 0, 3, 0, "R2 machine, mie on");
        apply(b(7), b(7), '0, 0, 0, 0, 1, 0, "R2 supervisor below machine");
        apply(b(7), b(7), '0, 0, 0, 0, 2, 0, "R2 reserved code");
        // R3 supervisor gate
        apply(b(5), b(5), b(5), 1, 0, 0, 1, 0, "R3 sup, sie off");
        apply(b(5), b(5), b(5), 1, 1, 0, 1, 0, "R3 sup, sie on");
        apply(b(5), b(5), b(5), 0, 0, 0, 0, 0, "R3 user");
        apply(b(5), b(5), b(5), 1, 1, 0, 3, 0, "R3 machine blocks delegated");
        apply(b(5), b(5), b(5), 1, 1, 0, 2, 0, "R3 reserved blocks delegated");
        // R4 mixed delegation
        apply(b(3) | b(11), '1, b(3), 1, 1, 0, 3, 0, "R4 delegated low blocked, 11 taken");
        // R5 priority
        apply(b(3) | b(7) | b(11), '1, '0, 1, 1, 1, 0, 0, "R5 lowest wins");
        apply(b(63) | b(40), '1, '0, 1, 1, 1, 0, 0, "R5 high bits");
        // R6 hypervisor path
        apply(b(9), '1, '0, 0, 0, 1, 1, 1, "R6 host cand forces hyp");
        apply(b(9) | b(2), '1, b(1), 1, 1, 1, 0, 1, "R6 host beats lower guest");
        // R7 hyp enable bit
        apply(b(9), '1, '0, 1, 1, 0, 1, 1, "R7 hyp bit off drops host cand");
        apply(b(9) | b(6), '1, b(5), 1, 1, 0, 1, 1, "R7 guest seen after host dropped");
        // R8 guest shift
        apply(b(6), '1, b(5), 0, 0, 0, 0, 1, "R8 guest 6 to 5 delegated");
        apply(b(6), '1, '0, 0, 0, 0, 0, 1, "R8 guest 6 to 5 not delegated");
        apply(b(10), '1, b(9), 1, 0, 0, 1, 1, "R8 guest 10, sie off");
        apply(b(10), '1, b(9), 1, 1, 0, 1, 1, "R8 guest 10, sie on");
        apply(b(2) | b(10), b(10), '0, 1, 1, 0, 3, 1, "R8 enable masks guest 2");
        for (int n = 0; n < 4000; n++) begin
            logic [XLEN-1:0] p, e, d;
            p = {$urandom, $urandom} & {$urandom, $urandom};
            if (n % 3 == 0) p = p & 64'h0000_0000_0000_0F66;
            e = {$urandom, $urandom} | {$urandom, $urandom};
            d = {$urandom, $urandom};
            apply(p, e, d, 1'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), "R4 R5 R6 R8 mixed");
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule